// File: doc/BRIEF.md
# DRAM page-mode sequencer

This block runs the access cycles for one DRAM area. Bus masters hand it requests with a valid/ready handshake. Each request carries an address, a read/write flag and write data. The block drives RAS, CAS, a write strobe and a shared row/column address bus. It remembers which row is open. A request to that row skips the precharge and row phases and goes straight to column cycles, and this holds whichever master issued it. A request to any other row closes the page, precharges and opens the new row.

Three static inputs shape the timing:
- `long_pitch` picks between two column timings. Long pitch uses two one-cycle column states, and WAIT can stretch the second one. Short pitch uses one column state of `TICKS` fast cycles, with CAS high for the first part of it.
- `cas_duty35` sets that high part in short pitch: 50 % when 0, 35 % when 1.
- `ras_down_en` decides what happens while another memory area owns the bus (`other_busy`). When 1, RAS stays low the whole time. When 0, RAS is raised, but the open-row record is kept.

Back-pressure rules:
- A master raises `req_valid` and holds it, together with `req_addr`, `req_we` and `req_wdata`, until it sees `req_ready` high at a rising edge.
- `req_ready` is a one-cycle pulse that marks the end of an access.
- The read response has no back-pressure. `rsp_valid` pulses once, and the master must take `rsp_rdata` in that cycle.

Top module: `dram_page_seq`

## Requirements
- R1: In reset and right after it, `ras_n`, `cas_n` and `we_n` are 1, and `req_ready` and `rsp_valid` are 0.
- R2: A request whose row is not the recorded open row (or with no row recorded yet) runs a precharge cycle with `ras_n`=1. It then runs a row cycle with `ras_n`=0 and the row (address bits above the column bits) on `dram_addr`, and then the column cycles. In long pitch with no wait, `req_ready` comes in the 4th cycle after acceptance.
- R3: A request to the open row while RAS is low goes straight to the column cycles. In long pitch with no wait, `req_ready` comes in the 2nd cycle.
- R4: In long pitch, a column access drives the column (low address bits) on `dram_addr` with `cas_n`=0 for two cycles, and `cas_n` is never 0 while `ras_n` is 1.
- R5: In long pitch, each cycle that WAIT (`wait_n`=0) is seen in the second column cycle repeats that cycle with CAS still low, adding one cycle per wait.
- R6: In short pitch, a column state lasts `TICKS` cycles. CAS is high for the first `TICKS/2` cycles when `cas_duty35`=0, and for the first `TICKS*7/20` cycles when it is 1, and low for the rest.
- R7: `we_n` is 0 and `dq_oe` is 1 only during the column cycles of a write, with `req_wdata` on `dq_o`.
- R8: For a read, `rsp_valid` pulses in the cycle after `req_ready`, carrying `dq_i` as seen in the final column cycle.
- R9: With `ras_down_en`=1, RAS stays low while `other_busy` is 1, and the next access to the open row is a page hit (R3 timing).
- R10: With `ras_down_en`=0, `other_busy` raises RAS from the next cycle. The open row stays recorded, so the next access to it runs one row cycle without precharge: 3 cycles in long pitch with no wait.
- R11: No access starts while `other_busy` is 1. `req_ready` stays 0 and CAS stays high until it drops.
- R12: `req_ready` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the CAS duty tick |
| rst_n | input | 1 | Synchronous reset, active low |
| ras_down_en | input | 1 | 1: hold RAS low while another area is busy |
| cas_duty35 | input | 1 | Short-pitch CAS high time: 0 = 50 %, 1 = 35 % |
| long_pitch | input | 1 | 1: two-state column cycles, 0: short-pitch column state |
| other_busy | input | 1 | Another memory area owns the bus |
| wait_n | input | 1 | External WAIT, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request completes this cycle |
| req_addr | input | ROW_W+COL_W | Row in high bits, column in low bits |
| req_we | input | 1 | 1 = write |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_rdata | output | DATA_W | Read data |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| dram_addr | output | ROW_W | Multiplexed row/column address |
| dq_o | output | DATA_W | Data toward the DRAM |
| dq_oe | output | 1 | Drive enable for `dq_o` |
| dq_i | input | DATA_W | Data from the DRAM |

## Verification
The bench builds the block with 4 row bits and 4 column bits, so that a handful of addresses gives page hits, row misses and returns to an older row. With 8-bit data, a 256-entry behavioural DRAM stays cheap, and it latches row and column on the strobe edges. `TICKS` keeps its default of 20, so the two short-pitch duties give distinct CAS-low counts of 10 and 13 cycles. The bench counts these exactly, next to the long-pitch wait counts of zero, one, two and three.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ROW,
    ST_COL1,
    ST_COL2,
    ST_SCOL
  } seq_state_t;

endpackage

// File: rtl/dram_row_track.sv
module dram_row_track #(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ROW_W-1:0] row_in,
  output logic             hit
);

  logic [ROW_W-1:0] open_row_q;
  logic             open_vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_row_q <= '0;
      open_vld_q <= 1'b0;
    end else if (load) begin
      open_row_q <= row_in;
      open_vld_q <= 1'b1;
    end
  end

  assign hit = open_vld_q && (open_row_q == row_in);

endmodule

// File: rtl/dram_cas_duty.sv
module dram_cas_duty #(
  parameter int TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic duty35,
  output logic cas_high,
  output logic last
);

  localparam int CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam int HI50  = TICKS / 2;
  localparam int HI35  = (TICKS * 7) / 20;

  logic [CNT_W-1:0] tick_q;
  logic [CNT_W-1:0] hi_lim;

  assign hi_lim   = duty35 ? CNT_W'(HI35) : CNT_W'(HI50);
  assign last     = run && (tick_q == CNT_W'(TICKS - 1));
  assign cas_high = tick_q < hi_lim;

  always_ff @(posedge clk) begin
    if (!rst_n || !run || last) tick_q <= '0;
    else                        tick_q <= tick_q + 1'b1;
  end

endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq
  import dram_seq_pkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int COL_W  = 8,
  parameter int DATA_W = 16,
  parameter int TICKS  = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ras_down_en,
  input  logic                   cas_duty35,
  input  logic                   long_pitch,
  input  logic                   other_busy,
  input  logic                   wait_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic                   req_we,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic                   ras_n,
  output logic                   cas_n,
  output logic                   we_n,
  output logic [ROW_W-1:0]       dram_addr,
  output logic [DATA_W-1:0]      dq_o,
  output logic                   dq_oe,
  input  logic [DATA_W-1:0]      dq_i
);

  localparam int ADDR_W = ROW_W + COL_W;

  seq_state_t st_q, st_d;
  logic       ras_on_q;
  logic       row_hit, duty_high, duty_last;
  logic       col_phase, done, start_ok;
  logic [ROW_W-1:0] row_of_req, col_wide;
  seq_state_t first_col;

  assign row_of_req = req_addr[ADDR_W-1:COL_W];

  always_comb begin
    col_wide = '0;
    col_wide[COL_W-1:0] = req_addr[COL_W-1:0];
  end

  dram_row_track #(.ROW_W(ROW_W)) u_row (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (st_q == ST_ROW),
    .row_in (row_of_req),
    .hit    (row_hit)
  );

  dram_cas_duty #(.TICKS(TICKS)) u_duty (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (st_q == ST_SCOL),
    .duty35   (cas_duty35),
    .cas_high (duty_high),
    .last     (duty_last)
  );

  assign start_ok  = req_valid && !other_busy;
  assign first_col = long_pitch ? ST_COL1 : ST_SCOL;
  assign col_phase = (st_q == ST_COL1) || (st_q == ST_COL2) || (st_q == ST_SCOL);
  assign done      = ((st_q == ST_COL2) && wait_n) || ((st_q == ST_SCOL) && duty_last);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_ok) begin
                 if (!row_hit)       st_d = ST_PRE;
                 else if (!ras_on_q) st_d = ST_ROW;
                 else                st_d = first_col;
               end
      ST_PRE:  st_d = ST_ROW;
      ST_ROW:  st_d = first_col;
      ST_COL1: st_d = ST_COL2;
      ST_COL2: if (wait_n) st_d = ST_IDLE;
      ST_SCOL: if (duty_last) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      ras_on_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_ROW)
        ras_on_q <= 1'b1;
      else if (st_q == ST_PRE)
        ras_on_q <= 1'b0;
      else if (st_q == ST_IDLE && other_busy && !ras_down_en)
        ras_on_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= done && !req_we;
      if (done && !req_we) rsp_rdata <= dq_i;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_IDLE: ras_n = !ras_on_q;
      ST_PRE:  ras_n = 1'b1;
      default: ras_n = 1'b0;
    endcase
    unique case (st_q)
      ST_COL1, ST_COL2: cas_n = 1'b0;
      ST_SCOL:          cas_n = duty_high;
      default:          cas_n = 1'b1;
    endcase
  end

  assign dram_addr = col_phase ? col_wide : row_of_req;
  assign we_n      = !(col_phase && req_we);
  assign dq_oe     = col_phase && req_we;
  assign dq_o      = req_wdata;
  assign req_ready = done;

endmodule

// File: rtl/dram_page_seq_chk.sv
module dram_page_seq_chk
  import dram_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       ras_down_en,
  input logic       other_busy,
  input logic       wait_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic       dq_oe,
  input logic       req_we,
  input logic       req_ready,
  input logic       rsp_valid,
  input seq_state_t st
);

  a_r12_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  a_r4_cas_under_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);

  a_r7_strobe_in_write_column: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ras_n && dq_oe && req_we));

  a_r5_wait_repeats: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_COL2 && !wait_n) |=> (st == ST_COL2 && !cas_n));

  a_r2_pre_then_row: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PRE) |=> (st == ST_ROW && !ras_n));

  a_r9_ras_held_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_down_en && other_busy && $past(other_busy) && !$past(ras_n)) |-> !ras_n);

  a_r10_ras_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && other_busy && !ras_down_en) |=> ras_n);

  a_r11_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && other_busy) |=> (st == ST_IDLE));

  a_r8_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(req_ready) && !$past(req_we)));

endmodule

bind dram_page_seq dram_page_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ras_down_en (ras_down_en),
  .other_busy  (other_busy),
  .wait_n      (wait_n),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .we_n        (we_n),
  .dq_oe       (dq_oe),
  .req_we      (req_we),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .st          (st_q)
);

// File: tb/dram_page_seq_tb.sv
module dram_page_seq_tb;

  localparam int RW = 4;
  localparam int CW = 4;
  localparam int DW = 8;
  localparam int TK = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_down_en = 1'b1, cas_duty35 = 1'b0, long_pitch = 1'b1;
  logic other_busy = 1'b0, wait_n = 1'b1;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [RW+CW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, ras_n, cas_n, we_n, dq_oe;
  logic [DW-1:0] rsp_rdata, dq_o, dq_i;
  logic [RW-1:0] dram_addr;

  int n_checks = 0;
  int n_fail = 0;
  int exp_q[$];
  logic [DW-1:0] shadow [256];
  logic [DW-1:0] mem [256];
  logic [RW-1:0] mrow = '0;
  logic [CW-1:0] mcol = '0;
  logic prev_ras = 1'b1, prev_cas = 1'b1;
  logic [RW-1:0] b_row = '0;
  bit b_vld = 0, b_ras = 0;

  always #10 clk = ~clk;

  dram_page_seq #(.ROW_W(RW), .COL_W(CW), .DATA_W(DW), .TICKS(TK)) u_dut (
    .clk(clk), .rst_n(rst_n), .ras_down_en(ras_down_en), .cas_duty35(cas_duty35),
    .long_pitch(long_pitch), .other_busy(other_busy), .wait_n(wait_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_we(req_we), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .dram_addr(dram_addr), .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i)
  );

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural DRAM: latch row on RAS fall, column on CAS fall
  assign dq_i = mem[{mrow, mcol}];
  always @(negedge clk) begin
    if (!ras_n && prev_ras) mrow <= dram_addr;
    if (!cas_n && prev_cas) begin
      mcol <= dram_addr[CW-1:0];
      if (ras_n) chk_eq("R4 cas fell with ras high", 1, 0);
    end
    if (!cas_n && !prev_cas && !we_n && dq_oe) mem[{mrow, mcol}] <= dq_o;
    prev_ras <= ras_n;
    prev_cas <= cas_n;
  end

  // scoreboard monitor for read data (R8)
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk_eq("R8 unexpected rsp_valid", 1, 0);
      else chk_eq("R8 read data", int'(rsp_rdata), exp_q.pop_front());
    end
  end

  task automatic access(input logic [7:0] addr, input bit we, input logic [7:0] wd,
                        input int nwait, input int busy);
    int k, cc, welow, exp_lat, pre, exp_col;
    bit hit;
    logic [RW-1:0] row;
    row = addr[7:4];
    req_addr = addr; req_we = we; req_wdata = wd; req_valid = 1'b1;
    other_busy = (busy > 0);
    for (int i = 0; i < busy; i++) begin
      @(negedge clk); #1;
      chk_eq("R11 ready while busy", int'(req_ready), 0);
      chk_eq("R11 cas while busy", int'(cas_n), 1);
      if (ras_down_en) chk_eq("R9 ras held low", int'(ras_n), 0);
      else             chk_eq("R10 ras raised", int'(ras_n), 1);
    end
    if (busy > 0 && !ras_down_en) b_ras = 0;
    other_busy = 1'b0;
    hit = b_vld && (b_row == row);
    pre = !hit ? 2 : (!b_ras ? 1 : 0);
    exp_col = long_pitch ? 2 + nwait : TK;
    exp_lat = pre + exp_col;
    if (!we) exp_q.push_back(int'(shadow[addr]));
    else     shadow[addr] = wd;
    k = 0; cc = 0; welow = 0;
    forever begin
      @(negedge clk);
      k++;
      if (!cas_n) cc++;
      if (!we_n) welow++;
      if (long_pitch && cc >= 2) wait_n = (cc - 1 > nwait);
      #1;
      if (req_ready || k > 200) break;
    end
    @(negedge clk);
    req_valid = 1'b0;
    wait_n = 1'b1;
    b_row = row; b_vld = 1; b_ras = 1;
    if (!hit)      chk_eq("R2 miss latency", k, exp_lat);
    else if (pre)  chk_eq("R10 reopen latency", k, exp_lat);
    else           chk_eq("R3 hit latency", k, exp_lat);
    if (!long_pitch)    chk_eq("R6 cas low cycles", cc, TK - (cas_duty35 ? (TK*7)/20 : TK/2));
    else if (nwait > 0) chk_eq("R5 cas low with wait", cc, exp_col);
    else                chk_eq("R4 cas low cycles", cc, exp_col);
    chk_eq("R7 we_n low cycles", welow, we ? exp_col : 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin shadow[i] = '0; mem[i] = '0; end
    repeat (3) @(negedge clk);
    chk_eq("R1 ras_n in reset", int'(ras_n), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R1 ras_n", int'(ras_n), 1);
    chk_eq("R1 cas_n", int'(cas_n), 1);
    chk_eq("R1 we_n", int'(we_n), 1);
    chk_eq("R1 ready", int'(req_ready), 0);
    chk_eq("R1 rsp_valid", int'(rsp_valid), 0);

    // long pitch, RAS down
    access(8'h12, 1, 8'hA5, 0, 0);
    access(8'h12, 0, 8'h00, 0, 0);
    access(8'h15, 1, 8'h3C, 0, 0);
    access(8'h15, 0, 8'h00, 1, 0);
    access(8'h12, 0, 8'h00, 3, 0);
    access(8'h27, 1, 8'h11, 0, 0);
    access(8'h15, 0, 8'h00, 0, 0);
    access(8'h17, 0, 8'h00, 0, 6);   // R9 + R11
    // RAS up
    ras_down_en = 1'b0;
    access(8'h1A, 0, 8'h00, 0, 4);   // R10 reopen without precharge
    access(8'h1B, 1, 8'h5E, 0, 0);
    access(8'h25, 0, 8'h00, 0, 3);   // R10 + different row
    access(8'h27, 0, 8'h00, 2, 0);
    // short pitch
    long_pitch = 1'b0;
    access(8'h26, 1, 8'h77, 0, 0);
    access(8'h26, 0, 8'h00, 0, 0);
    cas_duty35 = 1'b1;
    access(8'h27, 0, 8'h00, 0, 0);
    access(8'h12, 0, 8'h00, 0, 0);
    access(8'h1B, 0, 8'h00, 0, 2);
    long_pitch = 1'b1;
    access(8'h15, 0, 8'h00, 2, 0);
    repeat (3) @(negedge clk);
    chk_eq("R8 scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule